// File: doc/BRIEF.md
# Identity-Aware Remap Lookup Cache

This block is the lookup front end of a two-tier memory's remap metadata. A request carries a byte address. The block turns it into a translated byte address and a flag that names the tier. When the block has been moved into the fast tier, the result is the fast-tier slot. When the block is identity-mapped, the result is the block's own home address in the slow tier. The block offset passes through unchanged.

Two small, fully associative caches are probed in the same cycle. The remap cache holds explicit block-to-slot entries. The identity cache holds whole address ranges that are known to contain no moved block. When both caches miss, a two-level sparse radix table is walked one level per cycle. The root has one entry per range. A leaf node is taken from a small pool the first time a block in that range is installed. A walk that meets an unallocated root entry resolves to identity.

A maintenance port installs or evicts remaps and keeps both caches coherent with the table.

Top module: `remap_lookup`

## Requirements
- R1: After reset, req_ready and maint_ready are 1 and resp_valid is 0. Every lookup into the empty table returns resp_fast=0 with resp_addr equal to req_addr.
- R2: The block address is req_addr shifted right by log2(BLK_BYTES), where BLK_BYTES is 64, 128 or 256 and defaults to 64. Its upper ROOT_BITS bits (default 4) select the range and its lower bits select the leaf. The offset bits are copied into resp_addr.
- R3: A lookup that misses both caches and whose range has no leaf node responds 2 cycles after acceptance with resp_walked=1 and resp_fast=0.
- R4: A lookup that misses both caches and whose range has a leaf node responds 3 cycles after acceptance with resp_walked=1. A valid leaf gives resp_fast=1 and resp_addr = {slot, offset}. An empty leaf gives identity.
- R5: A lookup that hits either cache responds 1 cycle after acceptance with resp_walked=0.
- R6: A walk that ends at a valid leaf fills the remap cache with that block. A walk that ends at an unallocated root fills the identity cache for the whole range. A walk that ends at an empty leaf fills neither cache.
- R7: maint_evict=0 installs maint_slot for maint_blk. This invalidates the identity-cache entry of the block's range and any remap-cache entry for that block, so the next lookup returns the new slot.
- R8: maint_evict=1 clears the block's leaf and its remap-cache entry. The next lookup of that block walks 3 cycles and returns identity.
- R9: The leaf pool holds NODES nodes (default 4) that are never freed. An install into a range without a node while the pool is full has no effect.
- R10: req_ready is 0 from the acceptance of a double miss until the response cycle, and also whenever maint_valid is 1. maint_ready is 0 during a walk.
- R11: Each cache replaces entries round-robin over its ENTRIES slots (default 4). After ENTRIES further fills, the oldest entry is gone and its block walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request may be accepted |
| req_addr | input | PADDR_W | Byte address to translate |
| maint_valid | input | 1 | Install/evict command valid |
| maint_ready | output | 1 | Command accepted this cycle when valid |
| maint_evict | input | 1 | 1 = evict the remap, 0 = install a remap |
| maint_blk | input | PADDR_W-log2(BLK_BYTES) | Block address of the command |
| maint_slot | input | SLOT_W | Fast-tier slot for an install |
| resp_valid | output | 1 | Translation result valid for one cycle |
| resp_fast | output | 1 | 1 = fast-tier slot, 0 = home slow-tier address |
| resp_addr | output | PADDR_W | Translated byte address |
| resp_walked | output | 1 | 1 = result came from a radix walk |

## Verification
The assertions check several properties on every cycle: a cache hit always answers in the next cycle, a double miss always holds off the next request, walks step from the root level to the leaf level, a response from a walk never follows an idle cycle, no tag is matched twice in either cache, and the node pool never exceeds its size. What the caches actually hold can only be shown by the bench's scenarios, because it appears only in the latency of later lookups. This covers range-wide identity fills, the absence of a fill after an empty-leaf walk, invalidation on install and evict, round-robin loss of old entries, and a dropped install once the pool is full.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROOT = 2'd1,
    ST_LEAF = 2'd2
  } walk_st_t;
endpackage

// File: rtl/rlc_tag_cache.sv
module rlc_tag_cache #(
  parameter int TAG_W   = 10,
  parameter int DATA_W  = 6,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              inv_en,
  input  logic [TAG_W-1:0]  inv_tag
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [TAG_W-1:0]   ent_tag  [ENTRIES];
  logic [DATA_W-1:0]  ent_data [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;
  logic [PTR_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]  = ent_v[g] && (ent_tag[g] == lk_tag);
    assign inv_match[g] = ent_v[g] && (ent_tag[g] == inv_tag);
  end

  assign lk_hit = |lk_match;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_data = lk_data | ent_data[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      victim <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i]  <= '0;
        ent_data[i] <= '0;
      end
    end else begin
      if (inv_en) ent_v <= ent_v & ~inv_match;
      if (fill_en) begin
        ent_v[victim]    <= 1'b1;
        ent_tag[victim]  <= fill_tag;
        ent_data[victim] <= fill_data;
        victim <= (victim == PTR_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
      end
    end
  end

  // R6
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: rtl/rlc_radix_table.sv
module rlc_radix_table #(
  parameter int ROOT_BITS = 4,
  parameter int LEAF_BITS = 6,
  parameter int NODES     = 4,
  parameter int SLOT_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROOT_BITS-1:0]     rd_root,
  output logic                     root_valid,
  output logic [$clog2(NODES)-1:0] root_ptr,
  input  logic [$clog2(NODES)-1:0] rd_node,
  input  logic [LEAF_BITS-1:0]     rd_leaf,
  output logic                     leaf_valid,
  output logic [SLOT_W-1:0]        leaf_slot,
  input  logic                     wr_en,
  input  logic                     wr_evict,
  input  logic [ROOT_BITS-1:0]     wr_root,
  input  logic [LEAF_BITS-1:0]     wr_leaf,
  input  logic [SLOT_W-1:0]        wr_slot
);
  localparam int NODE_W = $clog2(NODES);
  localparam int CNT_W  = $clog2(NODES + 1);
  localparam int ROOT_N = 1 << ROOT_BITS;
  localparam int LEAF_TOTAL = NODES << LEAF_BITS;

  logic [ROOT_N-1:0]     r_v;
  logic [NODE_W-1:0]     r_p [ROOT_N];
  logic [LEAF_TOTAL-1:0] l_v;
  logic [SLOT_W-1:0]     l_s [LEAF_TOTAL];
  logic [CNT_W-1:0]      alloc_cnt;
  logic                  pool_room;
  logic [NODE_W-1:0]     new_node;

  assign pool_room  = alloc_cnt < CNT_W'(NODES);
  assign new_node   = alloc_cnt[NODE_W-1:0];
  assign root_valid = r_v[rd_root];
  assign root_ptr   = r_p[rd_root];
  assign leaf_valid = l_v[{rd_node, rd_leaf}];
  assign leaf_slot  = l_s[{rd_node, rd_leaf}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_v       <= '0;
      l_v       <= '0;
      alloc_cnt <= '0;
      for (int i = 0; i < ROOT_N; i++) r_p[i] <= '0;
      for (int i = 0; i < LEAF_TOTAL; i++) l_s[i] <= '0;
    end else if (wr_en) begin
      if (wr_evict) begin
        if (r_v[wr_root]) l_v[{r_p[wr_root], wr_leaf}] <= 1'b0;
      end else if (r_v[wr_root]) begin
        l_v[{r_p[wr_root], wr_leaf}] <= 1'b1;
        l_s[{r_p[wr_root], wr_leaf}] <= wr_slot;
      end else if (pool_room) begin
        r_v[wr_root] <= 1'b1;
        r_p[wr_root] <= new_node;
        l_v[{new_node, wr_leaf}] <= 1'b1;
        l_s[{new_node, wr_leaf}] <= wr_slot;
        alloc_cnt <= alloc_cnt + 1'b1;
      end
    end
  end

  // R9
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_cnt <= CNT_W'(NODES));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import rlc_pkg::*;
#(
  parameter int PADDR_W   = 16,
  parameter int BLK_BYTES = 64,
  parameter int ROOT_BITS = 4,
  parameter int NODES     = 4,
  parameter int SLOT_W    = 6,
  parameter int ENTRIES   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [PADDR_W-1:0]                   req_addr,
  input  logic                                 maint_valid,
  output logic                                 maint_ready,
  input  logic                                 maint_evict,
  input  logic [PADDR_W-$clog2(BLK_BYTES)-1:0] maint_blk,
  input  logic [SLOT_W-1:0]                    maint_slot,
  output logic                                 resp_valid,
  output logic                                 resp_fast,
  output logic [PADDR_W-1:0]                   resp_addr,
  output logic                                 resp_walked
);
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int BLK_W     = PADDR_W - OFS_W;
  localparam int LEAF_BITS = BLK_W - ROOT_BITS;
  localparam int NODE_W    = $clog2(NODES);

  function automatic logic [BLK_W-1:0] blk_of(input logic [PADDR_W-1:0] a);
    return a[PADDR_W-1:OFS_W];
  endfunction
  function automatic logic [OFS_W-1:0] ofs_of(input logic [PADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction
  function automatic logic [ROOT_BITS-1:0] root_of(input logic [BLK_W-1:0] b);
    return b[BLK_W-1:LEAF_BITS];
  endfunction
  function automatic logic [LEAF_BITS-1:0] leaf_of(input logic [BLK_W-1:0] b);
    return b[LEAF_BITS-1:0];
  endfunction
  function automatic logic [BLK_W-1:0] slot_blk(input logic [SLOT_W-1:0] s);
    return BLK_W'(s);
  endfunction

  walk_st_t          st;
  logic [BLK_W-1:0]  blk_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [NODE_W-1:0] node_q;

  logic [BLK_W-1:0]  req_blk;
  logic              accept, maint_go;
  logic              nid_hit, idc_hit, id_hit;
  logic [SLOT_W-1:0] nid_slot;
  logic [0:0]        idc_flag;
  logic              rt_root_v, rt_leaf_v;
  logic [NODE_W-1:0] rt_ptr;
  logic [SLOT_W-1:0] rt_slot;
  logic              walk_root_ident, walk_leaf_done, nid_fill, id_fill, id_inv;

  assign req_blk     = blk_of(req_addr);
  assign maint_ready = (st == ST_IDLE);
  assign req_ready   = (st == ST_IDLE) && !maint_valid;
  assign accept      = req_valid && req_ready;
  assign maint_go    = maint_valid && maint_ready;
  assign id_hit      = idc_hit && idc_flag[0];

  assign walk_root_ident = (st == ST_ROOT) && !rt_root_v;
  assign walk_leaf_done  = (st == ST_LEAF);
  assign nid_fill        = walk_leaf_done && rt_leaf_v;
  assign id_fill         = walk_root_ident;
  assign id_inv          = maint_go && !maint_evict;

  rlc_tag_cache #(.TAG_W(BLK_W), .DATA_W(SLOT_W), .ENTRIES(ENTRIES)) u_remap_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(req_blk), .lk_hit(nid_hit), .lk_data(nid_slot),
    .fill_en(nid_fill), .fill_tag(blk_q), .fill_data(rt_slot),
    .inv_en(maint_go), .inv_tag(maint_blk)
  );

  rlc_tag_cache #(.TAG_W(ROOT_BITS), .DATA_W(1), .ENTRIES(ENTRIES)) u_ident_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(root_of(req_blk)), .lk_hit(idc_hit), .lk_data(idc_flag),
    .fill_en(id_fill), .fill_tag(root_of(blk_q)), .fill_data(1'b1),
    .inv_en(id_inv), .inv_tag(root_of(maint_blk))
  );

  rlc_radix_table #(.ROOT_BITS(ROOT_BITS), .LEAF_BITS(LEAF_BITS), .NODES(NODES),
                    .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_root(root_of(blk_q)), .root_valid(rt_root_v), .root_ptr(rt_ptr),
    .rd_node(node_q), .rd_leaf(leaf_of(blk_q)),
    .leaf_valid(rt_leaf_v), .leaf_slot(rt_slot),
    .wr_en(maint_go), .wr_evict(maint_evict),
    .wr_root(root_of(maint_blk)), .wr_leaf(leaf_of(maint_blk)), .wr_slot(maint_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      blk_q       <= '0;
      ofs_q       <= '0;
      node_q      <= '0;
      resp_valid  <= 1'b0;
      resp_fast   <= 1'b0;
      resp_addr   <= '0;
      resp_walked <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (nid_hit) begin
            resp_valid  <= 1'b1;
            resp_fast   <= 1'b1;
            resp_addr   <= {slot_blk(nid_slot), ofs_of(req_addr)};
            resp_walked <= 1'b0;
          end else if (id_hit) begin
            resp_valid  <= 1'b1;
            resp_fast   <= 1'b0;
            resp_addr   <= req_addr;
            resp_walked <= 1'b0;
          end else begin
            blk_q <= req_blk;
            ofs_q <= ofs_of(req_addr);
            st    <= ST_ROOT;
          end
        end
        ST_ROOT: begin
          if (!rt_root_v) begin
            resp_valid  <= 1'b1;
            resp_fast   <= 1'b0;
            resp_addr   <= {blk_q, ofs_q};
            resp_walked <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            node_q <= rt_ptr;
            st     <= ST_LEAF;
          end
        end
        ST_LEAF: begin
          resp_valid  <= 1'b1;
          resp_fast   <= rt_leaf_v;
          resp_addr   <= rt_leaf_v ? {slot_blk(rt_slot), ofs_q} : {blk_q, ofs_q};
          resp_walked <= 1'b1;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (nid_hit || id_hit) |=> resp_valid && !resp_walked);

  // R10
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nid_hit && !id_hit |=> !resp_valid && !req_ready && !maint_ready);

  // R4
  walk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAF) |-> ($past(st) == ST_ROOT));

  // R3
  walk_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_walked |-> ($past(st) != ST_IDLE));
endmodule

// File: tb/tb_remap_lookup.sv
module tb_remap_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        maint_valid = 1'b0;
  logic        maint_ready;
  logic        maint_evict = 1'b0;
  logic [9:0]  maint_blk = '0;
  logic [5:0]  maint_slot = '0;
  logic        resp_valid, resp_fast, resp_walked;
  logic [15:0] resp_addr;

  int checks = 0;
  int errors = 0;
  int r_lat;
  logic r_fast, r_walked;
  logic [15:0] r_addr;

  always #2.5 clk = ~clk;

  remap_lookup dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .maint_valid(maint_valid), .maint_ready(maint_ready), .maint_evict(maint_evict),
    .maint_blk(maint_blk), .maint_slot(maint_slot),
    .resp_valid(resp_valid), .resp_fast(resp_fast), .resp_addr(resp_addr),
    .resp_walked(resp_walked)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic lookup(input int blk, input int ofs);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'((blk << 6) | ofs);
    @(posedge clk); #1;
    req_valid = 1'b0;
    r_lat = 1;
    while (!resp_valid && r_lat < 8) begin
      @(posedge clk); #1;
      r_lat++;
    end
    r_fast = resp_fast; r_addr = resp_addr; r_walked = resp_walked;
  endtask

  task automatic expect_lookup(input string rq, input int blk, input int ofs,
                               input bit fast, input int loc, input int lat);
    lookup(blk, ofs);
    check(rq, "latency", r_lat, lat);
    check(rq, "fast", int'(r_fast), int'(fast));
    check(rq, "addr", int'(r_addr), (loc << 6) | ofs);
    check(rq, "walked", int'(r_walked), int'(lat > 1));
  endtask

  task automatic maint(input bit ev, input int blk, input int slot);
    @(negedge clk);
    maint_valid = 1'b1; maint_evict = ev;
    maint_blk = 10'(blk); maint_slot = 6'(slot);
    @(posedge clk); #1;
    maint_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "req_ready", int'(req_ready), 1);
    check("R1", "maint_ready", int'(maint_ready), 1);
    check("R1", "resp_valid", int'(resp_valid), 0);
  endtask

  task automatic t_identity_range();
    expect_lookup("R1", 'h123, 5, 1'b0, 'h123, 2);
    expect_lookup("R6", 'h13F, 0, 1'b0, 'h13F, 1);
    expect_lookup("R2", 'h123, 63, 1'b0, 'h123, 1);
  endtask

  task automatic t_install_walk();
    maint(1'b0, 'h1A5, 9);
    expect_lookup("R4", 'h1A5, 7, 1'b1, 9, 3);
    expect_lookup("R5", 'h1A5, 1, 1'b1, 9, 1);
    expect_lookup("R4", 'h1A6, 0, 1'b0, 'h1A6, 3);
    expect_lookup("R6", 'h1A6, 0, 1'b0, 'h1A6, 3);
  endtask

  task automatic t_install_invalidates();
    maint(1'b0, 'h130, 5);
    expect_lookup("R7", 'h130, 2, 1'b1, 5, 3);
    expect_lookup("R7", 'h123, 0, 1'b0, 'h123, 3);
    maint(1'b0, 'h1A5, 12);
    expect_lookup("R7", 'h1A5, 0, 1'b1, 12, 3);
  endtask

  task automatic t_evict();
    maint(1'b1, 'h1A5, 0);
    expect_lookup("R8", 'h1A5, 4, 1'b0, 'h1A5, 3);
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < 4; i++) maint(1'b0, 'h180 + i, 20 + i);
    for (int i = 0; i < 4; i++) expect_lookup("R11", 'h180 + i, 0, 1'b1, 20 + i, 3);
    expect_lookup("R11", 'h183, 0, 1'b1, 23, 1);
    expect_lookup("R11", 'h130, 0, 1'b1, 5, 3);
    expect_lookup("R11", 'h180, 0, 1'b1, 20, 3);
  endtask

  task automatic t_pool_full();
    maint(1'b0, 'h200, 30);
    maint(1'b0, 'h240, 31);
    maint(1'b0, 'h280, 33);
    expect_lookup("R9", 'h280, 3, 1'b0, 'h280, 2);
    expect_lookup("R9", 'h240, 0, 1'b1, 31, 3);
  endtask

  task automatic t_ready();
    @(negedge clk);
    maint_valid = 1'b1; maint_evict = 1'b1; maint_blk = 10'h3FF;
    #0.5;
    check("R10", "req_ready with maint_valid", int'(req_ready), 0);
    @(posedge clk); #1;
    maint_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'(('h301 << 6));
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R10", "req_ready during walk", int'(req_ready), 0);
    check("R10", "maint_ready during walk", int'(maint_ready), 0);
    @(posedge clk); #1;
    check("R3", "resp_valid after root walk", int'(resp_valid), 1);
    check("R10", "req_ready at response", int'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_identity_range();
    t_install_walk();
    t_install_invalidates();
    t_evict();
    t_round_robin();
    t_pool_full();
    t_ready();
    summary();
    $finish;
  end
endmodule